// File: doc/BRIEF.md
# Unified Data Address Decoder

This block sits in the memory stage of a small pipelined 8-bit microcontroller. Loads, stores, stack operations and call/return sequences all address one flat data space: the register file sits at the bottom, the I/O file directly above it, and data memory above that. Each cycle the block takes at most one request from sixteen sources, eight for reads and eight for writes. It forms the flat address from the source's operand, decides which of the three resources the address falls in, and raises a single downstream request that carries the address local to that resource.

The sources in each direction are: pointers X, Y and Z; the stack pointer for push or pop; a direct 16-bit constant with an optional extended-page byte above it; and three program-counter byte slots. A call stores the program counter low byte first. A return loads it high byte first. Each sequence takes one byte per consecutive cycle, and the stack pointer input is held at its starting value for the whole sequence. Stack accesses report the new stack pointer on a strobed output. Every write also raises a request to the first bypass register. All outputs are registered, one clock after the request.

Top module: `udata_addr_unit`

## Requirements
- R1: A flat address in 0x00..0x1F selects the register file, with local address equal to the flat address. 0x20..0x5F selects the I/O file, with local address equal to the flat address minus 0x20. Addresses from 0x60 upward select data memory, with local address equal to the flat address minus 0x60.
- R2: Request bit 0, 1 and 2 (in either direction) use the X, Y and Z pointer values as the flat address.
- R3: Request bit 4 uses the flat address {page, k16}, with the page byte as bits 23..16.
- R4: Bit 3 is the stack access. A write (push) goes to address sp and reports sp_new = sp-1. A read (pop) goes to address sp+1 and reports sp_new = sp+1. Both raise sp_upd.
- R5: Read bits 5, 6 and 7 are the return bytes high, middle and low. They read at sp+1, sp+2 and sp+3 and report sp_new equal to that address.
- R6: Write bits 5, 6 and 7 are the call bytes low, middle and high. They store pc[7:0] at sp, pc[15:8] at sp-1 and pc[21:16] zero-extended at sp-2, and report sp_new as sp-1, sp-2 and sp-3.
- R7: The downstream request, local address, write data and stack update appear exactly one clock after the request. At most one resource strobe is raised. On an idle cycle every output is zero.
- R8: Every granted write raises bp_wr together with its write data. Reads raise no bp_wr and drive zero write data.
- R9: When several sources assert together, the lowest index of {wr_req, rd_req} wins (all reads before writes, bit 0 first), and err is raised.
- R10: A middle program-counter byte that does not directly follow the first byte of the same direction in the previous cycle raises err. The same holds for a last byte that does not directly follow the middle byte. The access is still issued.
- R11: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 8 | Read sources: X, Y, Z, stack, direct, PC high, PC middle, PC low |
| wr_req | input | 8 | Write sources: X, Y, Z, stack, direct, PC low, PC middle, PC high |
| ptr_x | input | 16 | X pointer value |
| ptr_y | input | 16 | Y pointer value |
| ptr_z | input | 16 | Z pointer value |
| sp | input | 16 | Stack pointer, held during a call/return sequence |
| k16 | input | 16 | Direct address constant |
| page | input | 8 | Extended page byte for direct access |
| pc | input | 22 | Program counter for call writes |
| wdata | input | 8 | Store data for non-call writes |
| rf_rd | output | 1 | Register file read request |
| rf_wr | output | 1 | Register file write request |
| io_req | output | 1 | I/O file access request |
| io_we | output | 1 | I/O access is a write |
| dm_rd | output | 1 | Data memory read request |
| dm_wr | output | 1 | Data memory write request |
| loc_addr | output | 24 | Address local to the selected resource |
| wr_data | output | 8 | Write data |
| bp_wr | output | 1 | Bypass register write request |
| sp_upd | output | 1 | Stack pointer update strobe |
| sp_new | output | 16 | New stack pointer value |
| err | output | 1 | Conflicting or out-of-order request |

## Verification
The assertions check on every cycle that at most one resource strobe is raised and that local addresses stay inside their resource. They also check that idle cycles produce no outputs, that reads and writes yield their matching strobe and bypass request a cycle later, that a lone push reports the decremented stack pointer, and that simultaneous sources raise err. Only the bench scenarios show the exact boundary split at 0x1F/0x20 and 0x5F/0x60 and the page concatenation. They also show the call and return byte orders with their data and addresses across three cycles, the priority winner, and the out-of-order detection, because each depends on the operand values and on history over several cycles.

// File: rtl/udata_addr_unit.sv
module udata_addr_unit #(
  parameter int PTR_W   = 16,
  parameter int PAGE_W  = 8,
  parameter int BIG_MEM = 1,
  parameter int PC_W    = 22,
  parameter int RF_SIZE = 32,
  parameter int IO_SIZE = 64,
  localparam int FW     = (BIG_MEM != 0) ? PTR_W + PAGE_W : PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rd_req,
  input  logic [7:0]        wr_req,
  input  logic [PTR_W-1:0]  ptr_x,
  input  logic [PTR_W-1:0]  ptr_y,
  input  logic [PTR_W-1:0]  ptr_z,
  input  logic [PTR_W-1:0]  sp,
  input  logic [PTR_W-1:0]  k16,
  input  logic [PAGE_W-1:0] page,
  input  logic [PC_W-1:0]   pc,
  input  logic [7:0]        wdata,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic              io_req,
  output logic              io_we,
  output logic              dm_rd,
  output logic              dm_wr,
  output logic [FW-1:0]     loc_addr,
  output logic [7:0]        wr_data,
  output logic              bp_wr,
  output logic              sp_upd,
  output logic [PTR_W-1:0]  sp_new,
  output logic              err
);

  localparam logic [FW-1:0] IO_BASE = FW'(RF_SIZE);
  localparam logic [FW-1:0] DM_BASE = FW'(RF_SIZE + IO_SIZE);

  logic [15:0] req_all;
  logic [3:0]  sel;
  logic        any, multi, is_wr, stack, seq_err;
  logic [2:0]  src;
  logic [FW-1:0]    direct, flat, local_a;
  logic [PTR_W-1:0] koff, sp_a, spn;
  logic [7:0]       wdat;
  logic             hit_rf, hit_io;
  logic [3:0]       prev_sel;
  logic             prev_v;

  assign req_all = {wr_req, rd_req};
  assign any     = |req_all;
  assign multi   = $countones(req_all) > 1;

  always_comb begin
    sel = '0;
    for (int i = 15; i >= 0; i--)
      if (req_all[i]) sel = 4'(i);
  end

  assign is_wr = sel[3];
  assign src   = sel[2:0];
  assign stack = (src == 3'd3) || (src >= 3'd5);

  generate
    if (BIG_MEM != 0) begin : g_paged
      assign direct = {page, k16};
    end else begin : g_flat
      assign direct = k16;
    end
  endgenerate

  assign koff = (src >= 3'd5) ? PTR_W'(src - 3'd5) : '0;
  assign sp_a = is_wr ? sp - koff : sp + koff + 1'b1;
  assign spn  = is_wr ? sp_a - 1'b1 : sp_a;

  always_comb begin
    case (src)
      3'd0:    flat = FW'(ptr_x);
      3'd1:    flat = FW'(ptr_y);
      3'd2:    flat = FW'(ptr_z);
      3'd4:    flat = direct;
      default: flat = FW'(sp_a);
    endcase
  end

  always_comb begin
    wdat = wdata;
    if (is_wr) begin
      case (src)
        3'd5:    wdat = pc[7:0];
        3'd6:    wdat = pc[15:8];
        3'd7:    wdat = 8'(pc >> 16);
        default: wdat = wdata;
      endcase
    end
  end

  assign hit_rf  = flat < IO_BASE;
  assign hit_io  = !hit_rf && (flat < DM_BASE);
  assign local_a = hit_rf ? flat : (hit_io ? flat - IO_BASE : flat - DM_BASE);

  assign seq_err = any && (src >= 3'd6) && !(prev_v && (prev_sel == sel - 4'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_rd <= 1'b0; rf_wr <= 1'b0; io_req <= 1'b0; io_we <= 1'b0;
      dm_rd <= 1'b0; dm_wr <= 1'b0; bp_wr <= 1'b0; sp_upd <= 1'b0;
      loc_addr <= '0; wr_data <= '0; sp_new <= '0; err <= 1'b0;
      prev_v <= 1'b0; prev_sel <= '0;
    end else begin
      rf_rd    <= any && !is_wr && hit_rf;
      rf_wr    <= any && is_wr && hit_rf;
      io_req   <= any && hit_io;
      io_we    <= any && is_wr && hit_io;
      dm_rd    <= any && !is_wr && !hit_rf && !hit_io;
      dm_wr    <= any && is_wr && !hit_rf && !hit_io;
      bp_wr    <= any && is_wr;
      loc_addr <= any ? local_a : '0;
      wr_data  <= (any && is_wr) ? wdat : '0;
      sp_upd   <= any && stack;
      sp_new   <= (any && stack) ? spn : '0;
      err      <= multi || seq_err;
      prev_v   <= any;
      prev_sel <= sel;
    end
  end

endmodule

module udata_addr_unit_chk #(
  parameter int FW    = 24,
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       rd_req,
  input logic [7:0]       wr_req,
  input logic [PTR_W-1:0] sp,
  input logic             rf_rd,
  input logic             rf_wr,
  input logic             io_req,
  input logic             io_we,
  input logic             dm_rd,
  input logic             dm_wr,
  input logic [FW-1:0]    loc_addr,
  input logic             bp_wr,
  input logic             sp_upd,
  input logic [PTR_W-1:0] sp_new,
  input logic             err
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rf_rd, rf_wr, io_req, dm_rd, dm_wr}) <= 1); // R7
  AST_RF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd || rf_wr) |-> (loc_addr < FW'(32))); // R1
  AST_IO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (loc_addr < FW'(64))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req == 8'd0 && wr_req == 8'd0) |=>
      !(rf_rd || rf_wr || io_req || dm_rd || dm_wr || bp_wr || sp_upd || err)); // R7
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req != 8'd0 && wr_req == 8'd0) |=> ((rf_rd || dm_rd || (io_req && !io_we)) && !bp_wr)); // R8
  AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req == 8'd0 && wr_req != 8'd0) |=> (bp_wr && (rf_wr || dm_wr || (io_req && io_we)))); // R8
  AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req == 8'd0 && wr_req == 8'b0000_1000) |=> (sp_upd && sp_new == $past(sp) - 1'b1)); // R4
  AST_MULTI_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({wr_req, rd_req}) > 1) |=> err); // R9
endmodule

bind udata_addr_unit udata_addr_unit_chk #(.FW(FW), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/sim_udata_addr_unit.sv
module sim_udata_addr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  rd_req = '0, wr_req = '0, page = '0, wdata = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0, sp = '0, k16 = '0;
  logic [21:0] pc = '0;
  logic rf_rd, rf_wr, io_req, io_we, dm_rd, dm_wr, bp_wr, sp_upd, err;
  logic [23:0] loc_addr;
  logic [7:0]  wr_data;
  logic [15:0] sp_new;

  udata_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .sp(sp), .k16(k16),
    .page(page), .pc(pc), .wdata(wdata),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .io_req(io_req), .io_we(io_we),
    .dm_rd(dm_rd), .dm_wr(dm_wr), .loc_addr(loc_addr), .wr_data(wr_data),
    .bp_wr(bp_wr), .sp_upd(sp_upd), .sp_new(sp_new), .err(err));

  int n_tests = 0, n_fail = 0;
  bit m_prev_v = 1'b0;
  int m_prev_sel = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stack_addr(input bit wrd, input int s, input logic [15:0] p);
    if (wrd) begin
      case (s)
        6: return p - 16'd1;
        7: return p - 16'd2;
        default: return p;
      endcase
    end
    case (s)
      6: return p + 16'd2;
      7: return p + 16'd3;
      default: return p + 16'd1;
    endcase
  endfunction

  task automatic step(input logic [7:0] r, input logic [7:0] w, input string tag);
    logic [15:0] all;
    int sel, cnt, s;
    bit wrd, spu, e_err, is_rf, is_io;
    logic [15:0] a, spn;
    logic [23:0] flat, loc;
    logic [7:0] d;
    logic [8:0] ef, af;
    @(negedge clk);
    rd_req = r; wr_req = w;
    all = {w, r}; sel = -1; cnt = 0;
    for (int i = 0; i < 16; i++)
      if (all[i]) begin cnt++; if (sel < 0) sel = i; end
    ef = '0; loc = '0; d = '0; spn = '0;
    if (sel >= 0) begin
      wrd = sel >= 8; s = sel % 8; spu = 1'b0; a = '0;
      case (s)
        0: flat = {8'h00, ptr_x};
        1: flat = {8'h00, ptr_y};
        2: flat = {8'h00, ptr_z};
        4: flat = {page, k16};
        default: begin
          a = stack_addr(wrd, s, sp); flat = {8'h00, a}; spu = 1'b1;
          spn = wrd ? a - 16'd1 : a;
        end
      endcase
      if (wrd) begin
        case (s)
          5: d = pc[7:0];
          6: d = pc[15:8];
          7: d = {2'b00, pc[21:16]};
          default: d = wdata;
        endcase
      end
      is_rf = flat <= 24'h1F;
      is_io = !is_rf && flat <= 24'h5F;
      loc = is_rf ? flat : (is_io ? flat - 24'h20 : flat - 24'h60);
      e_err = (cnt > 1) ||
              ((s == 6 || s == 7) && !(m_prev_v && m_prev_sel == sel - 1));
      ef = {!wrd && is_rf, wrd && is_rf, is_io, wrd && is_io,
            !wrd && !is_rf && !is_io, wrd && !is_rf && !is_io, wrd, spu, e_err};
    end
    @(posedge clk); #1;
    af = {rf_rd, rf_wr, io_req, io_we, dm_rd, dm_wr, bp_wr, sp_upd, err};
    chk(tag, "flags", 32'(af), 32'(ef));
    chk(tag, "loc_addr", 32'(loc_addr), 32'(loc));
    chk(tag, "wr_data", 32'(wr_data), 32'(d));
    chk(tag, "sp_new", 32'(sp_new), 32'(spn));
    m_prev_v = sel >= 0;
    m_prev_sel = sel;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rd_req = 8'hFF; wr_req = 8'h0F; ptr_x = 16'h0042;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset outputs",
        32'({rf_rd, rf_wr, io_req, io_we, dm_rd, dm_wr, bp_wr, sp_upd, err, loc_addr, wr_data, sp_new}), 32'd0);
    @(negedge clk); rd_req = '0; wr_req = '0; rst_n = 1'b1;
    step(8'h00, 8'h00, "R7");

    // R1 boundaries
    wdata = 8'h5A;
    ptr_x = 16'h001F; step(8'h01, 8'h00, "R1");
    ptr_x = 16'h0020; step(8'h01, 8'h00, "R1");
    ptr_x = 16'h005F; step(8'h00, 8'h01, "R1");
    ptr_x = 16'h0060; step(8'h00, 8'h01, "R1");
    ptr_x = 16'hFFFF; step(8'h01, 8'h00, "R1");
    // R2 pointers
    ptr_y = 16'h0003; step(8'h02, 8'h00, "R2");
    ptr_z = 16'h1234; wdata = 8'hC3; step(8'h00, 8'h04, "R2");
    // R3 direct with page
    page = 8'h02; k16 = 16'h0010; step(8'h10, 8'h00, "R3");
    page = 8'h00; k16 = 16'h0045; step(8'h00, 8'h10, "R3");
    // R4 push / pop
    sp = 16'h0100; wdata = 8'h77; step(8'h00, 8'h08, "R4");
    sp = 16'h00FF; step(8'h08, 8'h00, "R4");
    step(8'h00, 8'h00, "R7");
    // R5 return across the I/O/memory border
    sp = 16'h005E;
    step(8'h20, 8'h00, "R5"); step(8'h40, 8'h00, "R5"); step(8'h80, 8'h00, "R5");
    // R6 call
    sp = 16'h08F0; pc = 22'h2ABCDE;
    step(8'h00, 8'h20, "R6"); step(8'h00, 8'h40, "R6"); step(8'h00, 8'h80, "R6");
    step(8'h00, 8'h00, "R7");
    // R10 out of order
    step(8'h00, 8'h40, "R10");
    step(8'h00, 8'h00, "R10");
    step(8'h20, 8'h00, "R10"); step(8'h80, 8'h00, "R10");
    step(8'h00, 8'h20, "R10"); step(8'h40, 8'h00, "R10");
    // R9 priority
    ptr_x = 16'h0010; ptr_y = 16'h0200;
    step(8'h01, 8'h02, "R9");
    ptr_z = 16'h0030; step(8'h00, 8'h0C, "R9");
    step(8'h00, 8'h00, "R7");

    // R8 and R7 random mix
    for (int it = 0; it < 600; it++) begin
      logic [7:0] r, w;
      int kind;
      ptr_x = 16'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 130));
      ptr_y = 16'($urandom_range(0, 130)); ptr_z = 16'($urandom);
      sp = 16'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 140));
      k16 = 16'($urandom_range(0, 1) == 0 ? $urandom : $urandom_range(0, 130));
      page = 8'($urandom_range(0, 2) == 0 ? $urandom : 0);
      pc = 22'($urandom); wdata = 8'($urandom);
      kind = $urandom_range(0, 19);
      r = '0; w = '0;
      if (kind < 5) begin end
      else if (kind < 12) r[$urandom_range(0, 7)] = 1'b1;
      else if (kind < 17) w[$urandom_range(0, 7)] = 1'b1;
      else begin r = 8'($urandom); w = 8'($urandom); end
      step(r, w, (w != 0) ? "R8" : "R7");
    end
    step(8'h00, 8'h00, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule